// File: doc/BRIEF.md
# Trigger Event Capture with Timestamp

This block watches two external trigger lines that arrive with no relation to the local clock. Each line first crosses into the clock domain through a chain of flops. The block then compares the synchronized level with its value one cycle earlier, so a rise and a fall both count as an event. The first event on a line raises a sticky pending flag. In the same cycle, the block copies the running timestamp counter into that line's stamp register. That counter is the one that also stamps the video frames, so trigger times and frame times can be compared directly.

Software, or a neighbouring block, reads one 8-bit activity word. That word holds the pending flags and the present synchronized levels, and every other bit is zero. The reader clears pending flags with an acknowledge strobe and a per-channel mask. When a line fires again before its flag is acknowledged, the first timestamp is kept and an overflow flag is raised. A one-cycle strobe on each channel marks every cycle in which a new timestamp is loaded.

Top module: `trig_stamp_capture`

## Requirements
- R1: While rst_n is low, and on the first clock after it rises, activity, ovf_flags, evt_strobe and stamp_out are all zero.
- R2: Activity bit 1 is the pending flag of trigger 0 and bit 2 is the pending flag of trigger 1. A flag is set by either a rise or a fall of its line. The flag is first visible after the third rising clock edge that follows the change on the input.
- R3: Activity bit 5 shows the synchronized level of trigger 0 and bit 6 shows that of trigger 1. Each equals the input as sampled two rising clock edges earlier.
- R4: Activity bits 0, 3, 4 and 7 always read zero.
- R5: A first event loads stamp_out with the ts_count value that was present at the rising edge where the pending flag is set. Trigger 0 uses bits TS_W-1:0 and trigger 1 uses bits 2*TS_W-1:TS_W. The stamp holds its value at all other times.
- R6: evt_strobe[i] is high for exactly the one cycle in which channel i's stamp was newly loaded.
- R7: An event on a channel whose flag is set and is not being cleared leaves the stamp unchanged. It sets ovf_flags[i] and gives no strobe.
- R8: An edge with ack_valid high clears pending and overflow on every channel whose ack_mask bit is 1. A channel whose mask bit is 0 is not affected.
- R9: When an event arrives at the same edge as that channel's clear, the flag stays set. The new timestamp is loaded, the overflow flag is cleared and the strobe fires.
- R10: An acknowledge to a channel with nothing pending leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_async | input | 2 | Asynchronous trigger lines |
| ts_count | input | TS_W | Free-running timestamp shared with frame stamping |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_mask | input | 2 | Channels cleared by the acknowledge |
| activity | output | 8 | Pending flags (bits 1, 2) and live levels (bits 5, 6) |
| stamp_out | output | 2*TS_W | Captured timestamps, channel 0 in the low half |
| evt_strobe | output | 2 | One-cycle pulse when a stamp is loaded |
| ovf_flags | output | 2 | Second event seen before acknowledge |

## Verification
The level property assumes the trigger lines are low while reset is held, so the synchronizer contents match the sampled input history from the moment reset is released. The clear property assumes that pending flags fall only because of an acknowledge. The bench holds both lines at zero during reset and changes inputs only on falling clock edges, so every sample taken at a rising edge is clean. It uses a pseudo-random mix of toggles and acknowledges, plus directed cases that put an event and a clear on the same edge.

// File: rtl/trig_cap_pkg.sv
package trig_cap_pkg;
   timeunit 1ns; timeprecision 1ps;
   localparam int NUM_TRIG = 2;
   localparam int ACT_W    = 8;
   localparam int PEND_LSB = 1;
   localparam int LVL_LSB  = 5;
   localparam logic [ACT_W-1:0] USED_MASK = 8'b0110_0110;

   typedef struct packed {
      logic pend;
      logic ovf;
      logic strobe;
   } chan_stat_t;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   timeunit 1ns; timeprecision 1ps;

   logic [STAGES-1:0][W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("trig_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/trig_channel.sv
module trig_channel
   import trig_cap_pkg::*;
#(
   parameter int TS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lvl,
   input  logic            clr,
   input  logic [TS_W-1:0] ts,
   output chan_stat_t      stat,
   output logic [TS_W-1:0] stamp
);
   timeunit 1ns; timeprecision 1ps;

   logic lvl_q;
   logic edge_seen;

   assign edge_seen = lvl ^ lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         stat  <= '0;
         stamp <= '0;
      end else begin
         lvl_q       <= lvl;
         stat.strobe <= 1'b0;
         if (edge_seen && (!stat.pend || clr)) begin
            stat.pend   <= 1'b1;
            stat.ovf    <= 1'b0;
            stat.strobe <= 1'b1;
            stamp       <= ts;
         end else if (edge_seen) begin
            stat.ovf <= 1'b1;
         end else if (clr) begin
            stat.pend <= 1'b0;
            stat.ovf  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/trig_stamp_capture.sv
module trig_stamp_capture
   import trig_cap_pkg::*;
#(
   parameter int TS_W        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               trig_async,
   input  logic [TS_W-1:0]          ts_count,
   input  logic                     ack_valid,
   input  logic [1:0]               ack_mask,
   output logic [7:0]               activity,
   output logic [2*TS_W-1:0]        stamp_out,
   output logic [1:0]               evt_strobe,
   output logic [1:0]               ovf_flags
);
   timeunit 1ns; timeprecision 1ps;

   localparam int STAMP_W = NUM_TRIG * TS_W;

   generate
      if (TS_W < 1) begin : g_bad_ts
         $error("trig_stamp_capture: TS_W must be positive");
      end
   endgenerate

   logic [NUM_TRIG-1:0] lvl_sync;
   chan_stat_t          stat [NUM_TRIG];

   trig_sync #(.STAGES(SYNC_STAGES), .W(NUM_TRIG)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (trig_async),
      .q    (lvl_sync)
   );

   for (genvar i = 0; i < NUM_TRIG; i++) begin : g_chan
      trig_channel #(.TS_W(TS_W)) u_chan (
         .clk  (clk),
         .rst_n(rst_n),
         .lvl  (lvl_sync[i]),
         .clr  (ack_valid & ack_mask[i]),
         .ts   (ts_count),
         .stat (stat[i]),
         .stamp(stamp_out[i*TS_W +: TS_W])
      );
      assign evt_strobe[i] = stat[i].strobe;
      assign ovf_flags[i]  = stat[i].ovf;
   end

   always_comb begin
      activity = '0;
      for (int i = 0; i < NUM_TRIG; i++) begin
         activity[PEND_LSB+i] = stat[i].pend;
         activity[LVL_LSB+i]  = lvl_sync[i];
      end
   end
endmodule

// File: rtl/trig_stamp_capture_chk.sv
module trig_stamp_capture_chk #(
   parameter int TS_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        trig_async,
   input logic              ack_valid,
   input logic [1:0]        ack_mask,
   input logic [7:0]        activity,
   input logic [2*TS_W-1:0] stamp_out,
   input logic [1:0]        evt_strobe,
   input logic [1:0]        ovf_flags
);
   timeunit 1ns; timeprecision 1ps;

   // R4
   unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (activity & 8'b1001_1001) == 8'h00);

   for (genvar i = 0; i < 2; i++) begin : g_ch
      // R3
      live_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         activity[5+i] == $past(trig_async[i], 2));
      // R6
      strobe_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt_strobe[i] |-> activity[1+i]);
      // R7
      ovf_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_flags[i] |-> activity[1+i]);
      // R7
      ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ovf_flags[i]) |-> ($past(activity[1+i]) && !evt_strobe[i]));
      // R8
      pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(activity[1+i]) |-> $past(ack_valid && ack_mask[i]));
      // R5
      stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !evt_strobe[i] |-> $stable(stamp_out[i*TS_W +: TS_W]));
   end
endmodule

bind trig_stamp_capture trig_stamp_capture_chk #(.TS_W(TS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trig_async(trig_async),
   .ack_valid (ack_valid),
   .ack_mask  (ack_mask),
   .activity  (activity),
   .stamp_out (stamp_out),
   .evt_strobe(evt_strobe),
   .ovf_flags (ovf_flags)
);

// File: tb/trig_stamp_capture_test.sv
module trig_stamp_capture_test;
   timeunit 1ns; timeprecision 1ps;

   localparam int TS_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        trig_async = 2'b00;
   logic [TS_W-1:0]   ts_count = '0;
   logic              ack_valid = 1'b0;
   logic [1:0]        ack_mask = 2'b00;
   logic [7:0]        activity;
   logic [2*TS_W-1:0] stamp_out;
   logic [1:0]        evt_strobe;
   logic [1:0]        ovf_flags;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // reference state
   logic [1:0] hist[$];
   bit         m_pend[2];
   bit         m_ovf[2];
   bit         m_strb[2];
   logic [TS_W-1:0] m_stamp[2];
   logic [TS_W-1:0] ts_next = 32'h1000_0000;
   logic [31:0]     lfsr = 32'hACE1_2468;

   trig_stamp_capture #(.TS_W(TS_W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .trig_async(trig_async), .ts_count(ts_count),
      .ack_valid(ack_valid), .ack_mask(ack_mask), .activity(activity),
      .stamp_out(stamp_out), .evt_strobe(evt_strobe), .ovf_flags(ovf_flags)
   );

   always #2.5 clk = ~clk;

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] model_act();
      logic [7:0] a = '0;
      for (int i = 0; i < 2; i++) begin
         a[1+i] = m_pend[i];
         a[5+i] = hist[1][i];
      end
      return a;
   endfunction

   task automatic model_reset();
      hist = '{2'b00, 2'b00, 2'b00};
      for (int i = 0; i < 2; i++) begin
         m_pend[i] = 0; m_ovf[i] = 0; m_strb[i] = 0; m_stamp[i] = '0;
      end
   endtask

   // hist[0] = older sample, hist[1] = level visible, hist[2] = newest
   task automatic model_edge(logic [1:0] t, bit a, logic [1:0] m, logic [TS_W-1:0] ts);
      logic [1:0] ev = hist[1] ^ hist[0];
      hist.push_back(t);
      void'(hist.pop_front());
      for (int i = 0; i < 2; i++) begin
         bit clr = a && m[i];
         m_strb[i] = 0;
         if (ev[i] && (!m_pend[i] || clr)) begin
            m_pend[i] = 1; m_ovf[i] = 0; m_strb[i] = 1; m_stamp[i] = ts;
         end else if (ev[i]) begin
            m_ovf[i] = 1;
         end else if (clr) begin
            m_pend[i] = 0; m_ovf[i] = 0;
         end
      end
   endtask

   task automatic compare_all();
      logic [7:0] e = model_act();
      check("R2 pending bits", {62'd0, activity[2:1]}, {62'd0, e[2:1]});
      check("R3 level bits", {62'd0, activity[6:5]}, {62'd0, e[6:5]});
      check("R4 unused bits", {60'd0, activity[7], activity[4:3], activity[0]}, 64'd0);
      check("R5 stamps", stamp_out, {m_stamp[1], m_stamp[0]});
      check("R6 strobe", {62'd0, evt_strobe}, {62'd0, m_strb[1], m_strb[0]});
      check("R7 overflow", {62'd0, ovf_flags}, {62'd0, m_ovf[1], m_ovf[0]});
   endtask

   task automatic step(logic [1:0] t, bit a, logic [1:0] m);
      trig_async = t; ack_valid = a; ack_mask = m; ts_count = ts_next;
      @(posedge clk);
      model_edge(t, a, m, ts_count);
      ts_next = ts_next + 32'd7;
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) step(trig_async, 1'b0, 2'b00);
   endtask

   initial begin
      logic [7:0]      snap_act;
      logic [63:0]     snap_stamp;
      logic [TS_W-1:0] want_ts;
      model_reset();
      repeat (4) @(negedge clk);
      // R1: outputs during reset
      check("R1 activity in reset", {56'd0, activity}, 64'd0);
      check("R1 stamps in reset", stamp_out, 64'd0);
      check("R1 strobe/ovf in reset", {60'd0, evt_strobe, ovf_flags}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 activity after reset", {56'd0, activity}, 64'd0);

      // first rise on trigger 0
      step(2'b01, 0, 2'b00);
      step(2'b01, 0, 2'b00);
      want_ts = ts_next;
      step(2'b01, 0, 2'b00);
      check("R2 pend0 at bit 1", {63'd0, activity[1]}, 64'd1);
      check("R5 stamp0 value", {32'd0, stamp_out[31:0]}, {32'd0, want_ts});
      idle(3);
      // fall while pending -> overflow
      step(2'b00, 0, 2'b00);
      idle(4);
      check("R7 overflow set", {62'd0, ovf_flags}, 64'd1);
      check("R7 stamp kept", {32'd0, stamp_out[31:0]}, {32'd0, want_ts});
      // acknowledge channel 0 only, with channel 1 pending
      step(2'b10, 0, 2'b00);
      idle(4);
      step(2'b10, 1, 2'b01);
      idle(1);
      check("R8 ch0 cleared", {62'd0, activity[1], ovf_flags[0]}, 64'd0);
      check("R8 ch1 untouched", {63'd0, activity[2]}, 64'd1);
      step(2'b10, 1, 2'b10);
      idle(2);
      // acknowledge with nothing pending
      snap_act = activity; snap_stamp = stamp_out;
      step(2'b10, 1, 2'b11);
      idle(1);
      check("R10 activity unchanged", {56'd0, activity}, {56'd0, snap_act});
      check("R10 stamps unchanged", stamp_out, snap_stamp);
      // event coinciding with clear on channel 1
      step(2'b00, 0, 2'b00);
      idle(4);
      step(2'b10, 0, 2'b00);
      step(2'b10, 0, 2'b00);
      want_ts = ts_next;
      step(2'b10, 1, 2'b10);
      check("R9 pend kept", {63'd0, activity[2]}, 64'd1);
      check("R9 new stamp", {32'd0, stamp_out[63:32]}, {32'd0, want_ts});
      check("R9 strobe fired", {63'd0, evt_strobe[1]}, 64'd1);
      check("R9 ovf cleared", {63'd0, ovf_flags[1]}, 64'd0);
      step(2'b10, 1, 2'b11);
      idle(2);

      // pseudo-random mix
      for (int k = 0; k < 3000; k++) begin
         logic [1:0] t;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         t = trig_async ^ ((lfsr[3:1] == 3'b000) ? lfsr[5:4] : 2'b00);
         step(t, lfsr[9:7] == 3'b000, lfsr[11:10]);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule